// File: doc/BRIEF.md
# Two-dimensional radix-2x2 butterfly cell

This cell performs one step of a two-dimensional decimation-in-time FFT on four complex samples. The samples sit at the four corners of a square tile with half-size h: (u,v), (u+h,v), (u,v+h) and (u+h,v+h). The row-index twiddle W^u and the column-index twiddle W^v for the step come in with the samples. The cell returns four transformed samples in the same corner order. A row-column FFT needs one pass over the rows and a second pass over the columns. This cell does both combinations for a corner set in one operation, so the array controller can issue independent quadruples in any order.

Inside, four radix-2 butterflies form two layers. Each butterfly is a three-register pipeline: two registers for the complex multiply and one for the sum and difference. The first layer pairs samples that differ only in column index and uses W^v. The second layer pairs the first-layer results that differ only in row index and uses W^u. The row twiddle is delayed so that it meets its own data at the second layer. Each layer adds one bit of width.

Both the sample side and the result side use valid/ready handshakes. The whole pipeline advances together whenever the output register is empty or being taken. When a result is held at the output and refused, every stage freezes, `in_ready` drops, and no data is lost or duplicated.

Top module: `bfly2d_cell`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `out_ready` held at 1, a quadruple accepted on a clock edge appears on the outputs with `out_valid` = 1 exactly six clock edges later.
- R3: The first layer uses the column twiddle C. It forms A+ = s0 + C·s2, A- = s0 − C·s2, B+ = s1 + C·s3 and B- = s1 − C·s3. Here s0..s3 are input lanes 0..3, holding (u,v), (u+h,v), (u,v+h) and (u+h,v+h).
- R4: The second layer uses the row twiddle R. The output lanes are: lane 0 = A+ + R·B+, lane 1 = A+ − R·B+, lane 2 = A- + R·B-, lane 3 = A- − R·B-. These are the corners (u,v), (u+h,v), (u,v+h) and (u+h,v+h).
- R5: Twiddles are signed TW-bit fixed point with TW−2 fraction bits, so 1.0 is 2^(TW−2). Each complex product is formed exactly and then shifted right arithmetically by TW−2 bits (rounding toward minus infinity).
- R6: First-layer values are DW+1 bits and outputs are DW+2 bits. Each product and each sum or difference wraps in two's complement to its layer width.
- R7: A new quadruple, with its own twiddles, can be accepted on every clock. Each result uses only the twiddles presented together with its own samples.
- R8: While `out_valid` is 1 and `out_ready` is 0: `in_ready` is 0, the outputs hold their values, and the same result is delivered once `out_ready` rises.
- R9: `out_valid` rises only for accepted quadruples. Idle cycles between inputs reappear as the same gaps at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Quadruple and twiddles on the inputs are valid |
| in_ready | output | 1 | Cell accepts the quadruple on this edge |
| in_re | input | 4×DW | Real parts, lane k in bits [k*DW +: DW], corner order of R3 |
| in_im | input | 4×DW | Imaginary parts, same layout |
| tw_col_re | input | TW | Column twiddle W^v, real |
| tw_col_im | input | TW | Column twiddle W^v, imaginary |
| tw_row_re | input | TW | Row twiddle W^u, real |
| tw_row_im | input | TW | Row twiddle W^u, imaginary |
| out_valid | output | 1 | Results on the outputs are valid |
| out_ready | input | 1 | Downstream takes the results on this edge |
| out_re | output | 4×(DW+2) | Real results, lane order of R4 |
| out_im | output | 4×(DW+2) | Imaginary results, same layout |

## Verification
A hand-worked 2x2 case with unit twiddles catches swapped lanes or swapped layers. Those faults put the sums into the wrong corners. Quarter-turn twiddles, one per layer, expose a twiddle applied to the wrong layer or a real/imaginary cross-term with the wrong sign. Full-scale samples with a twiddle of −2.0 drive every layer into wraparound, so a datapath that is too narrow, or that saturates instead of wrapping, gives a different result. A stream with a fresh twiddle pair on every cycle, random output stalls and gapped input checks three things: a twiddle delay out of step with its data, a stall that drops or repeats a result, and a valid pipeline that loses bubbles or shifts timing.

// File: rtl/bfly2d_pkg.sv
package bfly2d_pkg;
  // register stages in one radix-2 butterfly: two for the multiply, one for add
  localparam int BF_MUL_LAT = 2;
  localparam int BF_LAT     = BF_MUL_LAT + 1;
  // two butterfly layers in series
  localparam int CELL_LAT   = 2 * BF_LAT;

  function automatic int tw_frac_bits(input int tw);
    return tw - 2;
  endfunction
endpackage

// File: rtl/bfly2d_cmul.sv
module bfly2d_cmul
  import bfly2d_pkg::*;
#(
  parameter int XW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [XW-1:0] x_re,
  input  logic signed [XW-1:0] x_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [XW:0]   p_re,
  output logic signed [XW:0]   p_im
);
  localparam int FRAC = tw_frac_bits(TW);
  localparam int PW   = XW + TW;
  localparam logic signed [TW-1:0] W_ONE = TW'(1 << FRAC);

  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [PW:0]   s_re, s_im, sh_re, sh_im;

  // stage 1: four partial products
  always_ff @(posedge clk) begin
    if (rst) begin
      m_rr <= '0;
      m_ii <= '0;
      m_ri <= '0;
      m_ir <= '0;
    end else if (en) begin
      m_rr <= x_re * w_re;
      m_ii <= x_im * w_im;
      m_ri <= x_re * w_im;
      m_ir <= x_im * w_re;
    end
  end

  always_comb begin
    s_re  = m_rr - m_ii;
    s_im  = m_ri + m_ir;
    sh_re = s_re >>> FRAC;
    sh_im = s_im >>> FRAC;
  end

  // stage 2: combine, scale, wrap to XW+1 bits
  always_ff @(posedge clk) begin
    if (rst) begin
      p_re <= '0;
      p_im <= '0;
    end else if (en) begin
      p_re <= sh_re[XW:0];
      p_im <= sh_im[XW:0];
    end
  end

  // R5: a twiddle of exactly 1.0 passes the operand unchanged
  p_unit_twiddle_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(en, 2) && !$past(rst, 2) &&
     $past(w_re, 2) == W_ONE && $past(w_im, 2) == '0)
    |-> (p_re == {$past(x_re[XW-1], 2), $past(x_re, 2)} &&
         p_im == {$past(x_im[XW-1], 2), $past(x_im, 2)}));
endmodule

// File: rtl/bfly2d_unit.sv
module bfly2d_unit
  import bfly2d_pkg::*;
#(
  parameter int XW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [XW-1:0] a_re,
  input  logic signed [XW-1:0] a_im,
  input  logic signed [XW-1:0] b_re,
  input  logic signed [XW-1:0] b_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [XW:0]   y0_re,
  output logic signed [XW:0]   y0_im,
  output logic signed [XW:0]   y1_re,
  output logic signed [XW:0]   y1_im
);
  logic signed [XW:0]   p_re, p_im;
  logic signed [XW-1:0] ad_re [BF_MUL_LAT];
  logic signed [XW-1:0] ad_im [BF_MUL_LAT];
  logic signed [XW:0]   ax_re, ax_im;

  bfly2d_cmul #(.XW(XW), .TW(TW)) u_cmul (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .x_re (b_re),
    .x_im (b_im),
    .w_re (w_re),
    .w_im (w_im),
    .p_re (p_re),
    .p_im (p_im)
  );

  // keep the direct operand in step with the multiplier
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BF_MUL_LAT; i++) begin
        ad_re[i] <= '0;
        ad_im[i] <= '0;
      end
    end else if (en) begin
      ad_re[0] <= a_re;
      ad_im[0] <= a_im;
      for (int i = 1; i < BF_MUL_LAT; i++) begin
        ad_re[i] <= ad_re[i-1];
        ad_im[i] <= ad_im[i-1];
      end
    end
  end

  assign ax_re = {ad_re[BF_MUL_LAT-1][XW-1], ad_re[BF_MUL_LAT-1]};
  assign ax_im = {ad_im[BF_MUL_LAT-1][XW-1], ad_im[BF_MUL_LAT-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      y0_re <= '0;
      y0_im <= '0;
      y1_re <= '0;
      y1_im <= '0;
    end else if (en) begin
      y0_re <= ax_re + p_re;
      y0_im <= ax_im + p_im;
      y1_re <= ax_re - p_re;
      y1_im <= ax_im - p_im;
    end
  end

  // R3: sum plus difference equals twice the direct operand (mod 2^(XW+1))
  logic [XW:0] chk_re, chk_im;
  assign chk_re = y0_re + y1_re;
  assign chk_im = y0_im + y1_im;
  p_sum_diff_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(en, 2) && $past(en, 3) && !$past(rst, 3))
    |-> (chk_re == {$past(a_re, 3), 1'b0} && chk_im == {$past(a_im, 3), 1'b0}));
endmodule

// File: rtl/bfly2d_cell.sv
module bfly2d_cell
  import bfly2d_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3:0][DW-1:0]   in_re,
  input  logic [3:0][DW-1:0]   in_im,
  input  logic [TW-1:0]        tw_col_re,
  input  logic [TW-1:0]        tw_col_im,
  input  logic [TW-1:0]        tw_row_re,
  input  logic [TW-1:0]        tw_row_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [3:0][DW+1:0]   out_re,
  output logic [3:0][DW+1:0]   out_im
);
  localparam int L1W = DW + 1;
  localparam int L2W = DW + 2;

  logic                  adv;
  logic [CELL_LAT-1:0]   vpipe;
  logic signed [TW-1:0]  trd_re [BF_LAT];
  logic signed [TW-1:0]  trd_im [BF_LAT];
  // first-layer results, [0] = sum form, [1] = difference form, index = pair
  logic signed [L1W-1:0] l1_re [2][2];
  logic signed [L1W-1:0] l1_im [2][2];
  logic signed [L2W-1:0] l2_re [4];
  logic signed [L2W-1:0] l2_im [4];

  // the whole pipe moves unless a held result is being refused
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else if (adv) vpipe <= {vpipe[CELL_LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[CELL_LAT-1];

  // row twiddle waits out the first layer
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BF_LAT; i++) begin
        trd_re[i] <= '0;
        trd_im[i] <= '0;
      end
    end else if (adv) begin
      trd_re[0] <= tw_row_re;
      trd_im[0] <= tw_row_im;
      for (int i = 1; i < BF_LAT; i++) begin
        trd_re[i] <= trd_re[i-1];
        trd_im[i] <= trd_im[i-1];
      end
    end
  end

  // layer 1: column index pairs, lane g with lane g+2
  for (genvar g = 0; g < 2; g++) begin : g_col
    bfly2d_unit #(.XW(DW), .TW(TW)) u_bf (
      .clk   (clk),
      .rst   (rst),
      .en    (adv),
      .a_re  (in_re[g]),
      .a_im  (in_im[g]),
      .b_re  (in_re[g+2]),
      .b_im  (in_im[g+2]),
      .w_re  (tw_col_re),
      .w_im  (tw_col_im),
      .y0_re (l1_re[0][g]),
      .y0_im (l1_im[0][g]),
      .y1_re (l1_re[1][g]),
      .y1_im (l1_im[1][g])
    );
  end

  // layer 2: row index pairs, same form from both first-layer pairs
  for (genvar k = 0; k < 2; k++) begin : g_row
    bfly2d_unit #(.XW(L1W), .TW(TW)) u_bf (
      .clk   (clk),
      .rst   (rst),
      .en    (adv),
      .a_re  (l1_re[k][0]),
      .a_im  (l1_im[k][0]),
      .b_re  (l1_re[k][1]),
      .b_im  (l1_im[k][1]),
      .w_re  (trd_re[BF_LAT-1]),
      .w_im  (trd_im[BF_LAT-1]),
      .y0_re (l2_re[2*k]),
      .y0_im (l2_im[2*k]),
      .y1_re (l2_re[2*k+1]),
      .y1_im (l2_im[2*k+1])
    );
  end

  for (genvar j = 0; j < 4; j++) begin : g_out
    assign out_re[j] = l2_re[j];
    assign out_im[j] = l2_im[j];
  end

  // R8: a refused result stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  // R8: input is refused only while a result is pending
  p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid);

  // R2 / R9: with the pipe moving, valid reappears six edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(adv, 1) && $past(adv, 2) && $past(adv, 3) &&
     $past(adv, 4) && $past(adv, 5) && $past(adv, 6) && !$past(rst, 6))
    |-> (out_valid == $past(in_valid, 6)));
endmodule

// File: tb/test_bfly2d_cell.sv
module test_bfly2d_cell;
  localparam int DW  = 16;
  localparam int TW  = 16;
  localparam int OW  = DW + 2;
  localparam int FR  = TW - 2;
  localparam longint ONE = 64'sd1 <<< FR;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic in_ready;
  logic [3:0][DW-1:0] in_re = '0, in_im = '0;
  logic [TW-1:0] tw_col_re = '0, tw_col_im = '0, tw_row_re = '0, tw_row_im = '0;
  logic out_valid;
  logic out_ready = 0;
  logic [3:0][OW-1:0] out_re, out_im;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic [3:0][OW-1:0] q_re[$], q_im[$];
  string q_tag[$];

  always #5 clk = ~clk;

  bfly2d_cell #(.DW(DW), .TW(TW)) i_bfly2d_cell (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im),
    .tw_col_re(tw_col_re), .tw_col_im(tw_col_im),
    .tw_row_re(tw_row_re), .tw_row_im(tw_row_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  function automatic longint wrapw(input longint v, input int w);
    longint t;
    t = v <<< (64 - w);
    return t >>> (64 - w);
  endfunction

  function automatic void cm(input longint xr, xi, wr, wi, input int w,
                             output longint pr, output longint pi);
    pr = wrapw((xr * wr - xi * wi) >>> FR, w);
    pi = wrapw((xr * wi + xi * wr) >>> FR, w);
  endfunction

  function automatic void model(output logic [3:0][OW-1:0] yr, output logic [3:0][OW-1:0] yi);
    longint xr[4], xi[4], ar[2][2], ai[2][2], pr, pi, cr, ci, rr, ri;
    cr = longint'($signed(tw_col_re)); ci = longint'($signed(tw_col_im));
    rr = longint'($signed(tw_row_re)); ri = longint'($signed(tw_row_im));
    for (int i = 0; i < 4; i++) begin
      xr[i] = longint'($signed(in_re[i]));
      xi[i] = longint'($signed(in_im[i]));
    end
    for (int g = 0; g < 2; g++) begin
      cm(xr[g+2], xi[g+2], cr, ci, DW + 1, pr, pi);
      ar[0][g] = wrapw(xr[g] + pr, DW + 1); ai[0][g] = wrapw(xi[g] + pi, DW + 1);
      ar[1][g] = wrapw(xr[g] - pr, DW + 1); ai[1][g] = wrapw(xi[g] - pi, DW + 1);
    end
    for (int k = 0; k < 2; k++) begin
      cm(ar[k][1], ai[k][1], rr, ri, OW, pr, pi);
      yr[2*k]   = OW'(wrapw(ar[k][0] + pr, OW)); yi[2*k]   = OW'(wrapw(ai[k][0] + pi, OW));
      yr[2*k+1] = OW'(wrapw(ar[k][0] - pr, OW)); yi[2*k+1] = OW'(wrapw(ai[k][0] - pi, OW));
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_vec(input bit ok, input string tag, input string what,
                           input logic [3:0][OW-1:0] act, input logic [3:0][OW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: score the output, record the input, advance, check holding
  task automatic step();
    logic pv, pr;
    logic [3:0][OW-1:0] pre, pim, er, ei;
    string t;
    #1;
    if (out_valid && out_ready) begin
      if (q_re.size() == 0) begin
        check(0, "R9", "unexpected out_valid", 1, 0);
      end else begin
        er = q_re.pop_front(); ei = q_im.pop_front(); t = q_tag.pop_front();
        check_vec(out_re == er, t, "out_re", out_re, er);
        check_vec(out_im == ei, t, "out_im", out_im, ei);
      end
    end
    if (out_valid && !out_ready)
      check(in_ready == 1'b0, "R8", "in_ready during stall", longint'(in_ready), 0);
    if (in_valid && in_ready) begin
      model(er, ei);
      q_re.push_back(er); q_im.push_back(ei); q_tag.push_back(cur_tag);
    end
    pv = out_valid; pr = out_ready; pre = out_re; pim = out_im;
    @(posedge clk); #1;
    if (pv && !pr) begin
      check(out_valid == 1'b1, "R8", "valid held", longint'(out_valid), 1);
      check_vec(out_re == pre && out_im == pim, "R8", "data held", out_re, pre);
    end
  endtask

  task automatic drain();
    in_valid = 0;
    out_ready = 1;
    for (int i = 0; i < 40 && q_re.size() != 0; i++) step();
    check(q_re.size() == 0, cur_tag, "results outstanding", q_re.size(), 0);
  endtask

  function automatic logic [DW-1:0] rdat();
    return DW'($urandom);
  endfunction

  function automatic logic [TW-1:0] rtw();
    return TW'(longint'($urandom_range(0, 2 * ONE)) - ONE);
  endfunction

  task automatic set_rand();
    for (int i = 0; i < 4; i++) begin
      in_re[i] = rdat(); in_im[i] = rdat();
    end
    tw_col_re = rtw(); tw_col_im = rtw();
    tw_row_re = rtw(); tw_row_im = rtw();
  endtask

  task automatic t_reset();
    cur_tag = "R1";
    rst = 1;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
  endtask

  // R3 R4: unit twiddles, hand-worked 2x2 sums
  task automatic t_hand();
    logic [3:0][OW-1:0] er;
    cur_tag = "R4";
    in_re = {16'sd4, 16'sd3, 16'sd2, 16'sd1};
    in_im = '0;
    tw_col_re = TW'(ONE); tw_col_im = '0;
    tw_row_re = TW'(ONE); tw_row_im = '0;
    out_ready = 1;
    in_valid = 1;
    step();
    in_valid = 0;
    while (!out_valid) step();
    er = {OW'(0), -OW'(4), -OW'(2), OW'(10)};
    check_vec(out_re == er, "R3", "hand 2x2 real", out_re, er);
    check_vec(out_im == '0, "R4", "hand 2x2 imag", out_im, '0);
    drain();
  endtask

  // R2: count edges from acceptance to valid result
  task automatic t_latency();
    int n;
    cur_tag = "R2";
    set_rand();
    out_ready = 1;
    in_valid = 1;
    step();
    in_valid = 0;
    n = 1;
    while (!out_valid && n < 20) begin
      step();
      n++;
    end
    check(n == 6, "R2", "latency in edges", n, 6);
    drain();
  endtask

  // R5: quarter-turn twiddles, one per layer
  task automatic t_quarter();
    cur_tag = "R5";
    out_ready = 1;
    for (int i = 0; i < 4; i++) begin
      set_rand();
      tw_col_re = '0; tw_col_im = TW'(-ONE);
      tw_row_re = '0; tw_row_im = TW'(ONE);
      if (i >= 2) begin
        tw_col_re = TW'(ONE / 2); tw_col_im = TW'(-3);
        tw_row_re = TW'(-ONE);    tw_row_im = TW'(ONE / 3);
      end
      in_valid = 1;
      step();
    end
    drain();
  endtask

  // R6: full-scale samples and a -2.0 twiddle force wraparound
  task automatic t_wrap();
    cur_tag = "R6";
    out_ready = 1;
    for (int i = 0; i < 3; i++) begin
      in_re = {4{16'h7fff}};
      in_im = {4{16'h8000}};
      tw_col_re = TW'(-2 * ONE); tw_col_im = (i == 1) ? TW'(-2 * ONE) : '0;
      tw_row_re = (i == 2) ? TW'(2 * ONE - 1) : TW'(-2 * ONE);
      tw_row_im = TW'(2 * ONE - 1);
      in_valid = 1;
      step();
    end
    drain();
  endtask

  // R7: back-to-back quadruples, fresh twiddles each cycle
  task automatic t_stream();
    int acc;
    cur_tag = "R7";
    out_ready = 1;
    acc = 0;
    for (int i = 0; i < 24; i++) begin
      set_rand();
      in_valid = 1;
      #1;
      if (in_ready) acc++;
      step();
    end
    check(acc == 24, "R7", "accepted every cycle", acc, 24);
    drain();
  endtask

  // R8: random output stalls under continuous input
  task automatic t_stall();
    cur_tag = "R8";
    for (int i = 0; i < 60; i++) begin
      set_rand();
      in_valid = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 2) != 0);
      step();
    end
    drain();
  endtask

  // R9: gaps in the input reappear unchanged at the output
  task automatic t_gaps();
    bit iv[24];
    bit ov[24];
    cur_tag = "R9";
    out_ready = 1;
    for (int i = 0; i < 24; i++) begin
      set_rand();
      iv[i] = (i < 12) && ((i % 3 == 0) || (i == 7));
      in_valid = iv[i];
      step();
      ov[i] = out_valid;
    end
    for (int i = 0; i + 5 < 24; i++)
      check(ov[i+5] == iv[i], "R9", $sformatf("valid gap at %0d", i),
            longint'(ov[i+5]), longint'(iv[i]));
    drain();
  endtask

  initial begin
    t_reset();
    t_hand();
    t_latency();
    t_quarter();
    t_wrap();
    t_stream();
    t_stall();
    t_gaps();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule